// File: doc/BRIEF.md
# Pointer-addressed two-wire target

This block is a target-only serial interface for a two-wire bus (I2C / SMBus compatible) that fronts a small internal register file. It over-samples the SCL and SDA lines with the system clock, cleans them with a synchroniser and a pulse filter, and recognises START and STOP events. It takes in the 7-bit target address followed by a direction bit and answers on the ninth clock only when the address is its own. It never drives the data line high: its only output is an enable that pulls SDA low.

The target address is chosen by two strap inputs. Each strap is encoded as low, high or floating, which gives nine possible addresses. In a write transaction the first data byte sets a register pointer, and any further bytes write the selected register, high byte first. A read transaction returns the register that the pointer names. The pointer keeps its value across any number of read transactions, so a host can set it once and then poll the same register. It can also set it with a short write and follow at once with a repeated START and a read.

Top module: `twi_ptr_target`

## Requirements
- R1: A START (SDA falling while SCL is high) at any point drops any partly received byte or pair and restarts address reception. A STOP (SDA rising while SCL is high) releases SDA and idles the block until the next START.
- R2: The address is taken from the straps on the first clock after reset. Strap codes are 00 = low, 01 = high, 10 or 11 = floating. For the pair (first strap, second strap): (0,0)→0x4C, (0,1)→0x4D, (1,0)→0x4E, (1,1)→0x4F, (0,F)→0x48, (F,0)→0x49, (1,F)→0x4A, (F,1)→0x4B, (F,F)→0x37. Strap changes after that capture have no effect until the next reset.
- R3: The address byte is seven address bits, MSB first, then a direction bit (1 = read, 0 = write). SDA is pulled low on the ninth clock only when the address matches. On a mismatch SDA is not pulled for the rest of the transaction.
- R4: In a write, the first byte after the address byte is stored as the pointer. Only its low PTR_W bits (3 by default) select the register. Every byte received in a matched write is acknowledged.
- R5: Data bytes in a write go high byte first, then low byte. The register is updated when its low byte arrives. Further pairs in the same transaction rewrite the same register, and a pair left incomplete is discarded.
- R6: A read sends the selected register high byte first, then low byte. If the host keeps reading, the same register repeats. Reads never change the pointer.
- R7: A host NACK after a read byte ends the output. SDA stays released until the next START or STOP.
- R8: A write made of only the address byte and the pointer byte, followed by a repeated START with the read bit set, returns the newly pointed register.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks is ignored.
- R10: SDA is only ever pulled low through an output enable. The enable is released in reset and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| strap_a0 | input | 2 | First address strap (00 low, 01 high, 1x floating) |
| strap_a1 | input | 2 | Second address strap (00 low, 01 high, 1x floating) |
| sda_pull | output | 1 | High pulls SDA low; low leaves the line released |

## Verification
The assertions assume a well-behaved bus host. It changes SDA only while SCL is low, except when it makes a START or STOP, and it holds each SCL phase well beyond the synchroniser and filter delay. The stimulus meets both conditions: every bus phase lasts twenty system clocks against a four-clock filter, and each transfer opens with a proper START and ends with a proper STOP or repeated START. The only deliberate breaks are glitches shorter than the filter length, injected on SCL and SDA while SCL is high. These are there to show that such pulses leave the transfer intact.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for START
    S_RX,     // shifting in a byte from the host
    S_ACK,    // holding SDA low during the ninth clock
    S_TX,     // shifting a byte out to the host
    S_MACK,   // sampling the host acknowledge
    S_HOLD    // released, waiting for START or STOP
  } twi_st_e;

  // strap level: 0 = low, 1 = high, 2 = floating
  function automatic logic [1:0] strap_level(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [6:0] strap_addr(input logic [1:0] c0, input logic [1:0] c1);
    logic [3:0] key;
    key = {strap_level(c0), strap_level(c1)};
    case (key)
      4'b00_00: return 7'h4C;
      4'b00_01: return 7'h4D;
      4'b01_00: return 7'h4E;
      4'b01_01: return 7'h4F;
      4'b00_10: return 7'h48;
      4'b10_00: return 7'h49;
      4'b01_10: return 7'h4A;
      4'b10_01: return 7'h4B;
      4'b10_10: return 7'h37;
      default:  return 7'h4C;
    endcase
  endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;

  logic [1:0]    sync;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], raw};
  end

  // the output only follows after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= 1'b1;
      run  <= '0;
    end else if (sync[1] == filt) begin
      run <= '0;
    end else if (run == CW'(FILT_LEN - 1)) begin
      filt <= sync[1];
      run  <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> (filt == $past(sync[1]))); // R9

endmodule

// File: rtl/twi_addr_sel.sv
module twi_addr_sel
  import twi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_a0,
  input  logic [1:0] strap_a1,
  output logic [6:0] dev_addr
);
  logic latched;

  always_ff @(posedge clk) begin
    if (rst) begin
      latched  <= 1'b0;
      dev_addr <= '0;
    end else if (!latched) begin
      dev_addr <= strap_addr(strap_a0, strap_a1);
      latched  <= 1'b1;
    end
  end

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    latched |=> $stable(dev_addr)); // R2

endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int PTR_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twi_ptr_target.sv
module twi_ptr_target
  import twi_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int PTR_W    = 3,
  parameter int DATA_W   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] strap_a0,
  input  logic [1:0] strap_a1,
  output logic       sda_pull
);
  localparam int NB    = DATA_W / 8;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int SW    = DATA_W - 8;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

  // ---------------- line conditioning ----------------
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    twi_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_lines[g]),
      .filt (filt_lines[g])
    );
  end

  logic scl_f, sda_f, scl_d, sda_d;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  logic ev_start, ev_stop, scl_rise, scl_fall;
  assign ev_start = scl_f & scl_d & sda_d & ~sda_f;
  assign ev_stop  = scl_f & scl_d & ~sda_d & sda_f;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;

  // ---------------- address straps ----------------
  logic [6:0] dev_addr;

  twi_addr_sel u_addr (
    .clk      (clk),
    .rst      (rst),
    .strap_a0 (strap_a0),
    .strap_a1 (strap_a1),
    .dev_addr (dev_addr)
  );

  // ---------------- register file ----------------
  logic [PTR_W-1:0]  ptr;
  logic              we;
  logic [DATA_W-1:0] wdata, rdata;

  twi_regfile #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .we    (we),
    .waddr (ptr),
    .wdata (wdata),
    .raddr (ptr),
    .rdata (rdata)
  );

  // ---------------- byte controller ----------------
  twi_st_e          st;
  logic [3:0]       cnt;
  logic [7:0]       shreg, tx;
  logic             is_addr, rd_mode, first_dat, mack;
  logic [IDX_W-1:0] bidx, nidx;
  logic [SW-1:0]    stage;
  logic [7:0]       nxt_byte;

  always_comb begin
    int sel_lo;
    nidx     = (bidx == LAST) ? '0 : bidx + 1'b1;
    sel_lo   = (NB - 1 - int'(nidx)) * 8;
    nxt_byte = rdata[sel_lo +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      is_addr   <= 1'b0;
      rd_mode   <= 1'b0;
      first_dat <= 1'b0;
      mack      <= 1'b0;
      bidx      <= '0;
      stage     <= '0;
      ptr       <= '0;
      we        <= 1'b0;
      wdata     <= '0;
      sda_pull  <= 1'b0;
    end else begin
      we <= 1'b0;
      if (ev_start) begin
        st       <= S_RX;
        cnt      <= '0;
        is_addr  <= 1'b1;
        bidx     <= '0;
        sda_pull <= 1'b0;
      end else if (ev_stop) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_f};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (is_addr) begin
                if (shreg[7:1] == dev_addr) begin
                  sda_pull  <= 1'b1;
                  st        <= S_ACK;
                  rd_mode   <= shreg[0];
                  first_dat <= 1'b1;
                  bidx      <= '0;
                end else begin
                  st <= S_HOLD;
                end
              end else begin
                sda_pull <= 1'b1;
                st       <= S_ACK;
                if (first_dat) begin
                  ptr       <= shreg[PTR_W-1:0];
                  first_dat <= 1'b0;
                end else if (bidx == LAST) begin
                  we    <= 1'b1;
                  wdata <= {stage, shreg};
                  bidx  <= '0;
                end else begin
                  stage <= (stage << 8) | SW'(shreg);
                  bidx  <= bidx + 1'b1;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              is_addr <= 1'b0;
              cnt     <= '0;
              if (rd_mode) begin
                tx       <= rdata[DATA_W-1 -: 8];
                sda_pull <= ~rdata[DATA_W-1];
                st       <= S_TX;
              end else begin
                sda_pull <= 1'b0;
                st       <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise && cnt < 4'd8) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt != 4'd0) begin
              if (cnt == 4'd8) begin
                sda_pull <= 1'b0;
                st       <= S_MACK;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_pull <= ~tx[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_f;
            end else if (scl_fall) begin
              if (mack) begin
                bidx     <= nidx;
                tx       <= nxt_byte;
                sda_pull <= ~nxt_byte[7];
                cnt      <= '0;
                st       <= S_TX;
              end else begin
                st <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_f); // R10

  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACK && is_addr) |-> (shreg[7:1] == dev_addr)); // R3

  AST_PTR_HELD_READ: assert property (@(posedge clk) disable iff (rst)
    (st == S_TX || st == S_MACK) |=> $stable(ptr)); // R6

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= 4'd8); // R4

  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |-> !rd_mode); // R5

  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD) |-> !sda_pull); // R7

endmodule

// File: tb/twi_ptr_target_bench.sv
module twi_ptr_target_bench;
  localparam int FILT = 4;
  localparam int Q    = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap_a0 = 2'b00, strap_a1 = 2'b00;
  logic       sda_pull;
  logic       sda_line;

  int n_chk = 0, n_err = 0, viol = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  twi_ptr_target #(.FILT_LEN(FILT), .PTR_W(3), .DATA_W(16)) u_twi_ptr_target (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (m_scl),
    .sda_in   (sda_line),
    .strap_a0 (strap_a0),
    .strap_a1 (strap_a1),
    .sda_pull (sda_pull)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R10 monitor: the pull enable must not move while SCL is high
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_pull != prev_pull && m_scl) viol++;
    prev_pull <= sda_pull;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    logic [7:0] g, e;
    string t;
    if (got_q.size() != 0) begin
      g = got_q.pop_front();
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard underflow", g, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait();
  endtask

  // glitch: 0 none, 1 short SCL low pulse, 2 short SDA low pulse (bit must be 1)
  task automatic put_bit(input logic b, input int glitch);
    m_sda = b; qwait();
    m_scl = 1'b1; qwait();
    if (glitch == 1) begin
      m_scl = 1'b0; repeat (FILT - 1) @(negedge clk); m_scl = 1'b1;
    end else if (glitch == 2) begin
      m_sda = 1'b0; repeat (FILT - 1) @(negedge clk); m_sda = 1'b1;
    end
    qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    b = sda_line; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] v, input int gpos, input int gkind, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i], (i == gpos) ? gkind : 0);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit ack);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!ack, 0);
    got_q.push_back(v);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] p, input logic [15:0] v, input string tag);
    bit a0, a1, a2, a3;
    bus_start();
    send_byte({a, 1'b0}, -1, 0, a0);
    send_byte(p, -1, 0, a1);
    send_byte(v[15:8], -1, 0, a2);
    send_byte(v[7:0], -1, 0, a3);
    bus_stop();
    chk(a0 && a1 && a2 && a3, tag, {a0, a1, a2, a3}, 4'hF);
  endtask

  task automatic set_ptr(input logic [6:0] a, input logic [7:0] p, input string tag);
    bit a0, a1;
    bus_start();
    send_byte({a, 1'b0}, -1, 0, a0);
    send_byte(p, -1, 0, a1);
    chk(a0 && a1, tag, {a0, a1}, 2'b11);
  endtask

  task automatic read_open(input logic [6:0] a, input string tag);
    bit ak;
    bus_start();
    send_byte({a, 1'b1}, -1, 0, ak);
    chk(ak, tag, ak, 1);
  endtask

  task automatic ping(input logic [6:0] a, input bit want, input string tag);
    bit ak;
    bus_start();
    send_byte({a, 1'b0}, -1, 0, ak);
    bus_stop();
    chk(ak == want, tag, ak, want);
  endtask

  task automatic do_reset(input logic [1:0] s0, input logic [1:0] s1);
    rst = 1'b1;
    strap_a0 = s0;
    strap_a1 = s1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog timeout", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin : main
    bit ak, b0, b1, b2;
    logic bl;
    do_reset(2'b00, 2'b00);
    chk(sda_pull == 1'b0, "R10 reset release", sda_pull, 0);

    // R4 R5: write register 2 and 5
    write_reg(7'h4C, 8'h02, 16'hA53C, "R4 write ack reg2");
    write_reg(7'h4C, 8'h05, 16'h1234, "R5 write ack reg5");

    // R8: pointer-only write then repeated START read, R6 wrap
    set_ptr(7'h4C, 8'h02, "R8 pointer write ack");
    read_open(7'h4C, "R8 read address ack");
    expect_rd(8'hA5, "R8 high byte");
    expect_rd(8'h3C, "R8 low byte");
    expect_rd(8'hA5, "R6 repeat after last byte");
    recv_byte(1); recv_byte(1); recv_byte(0);
    bus_stop();

    // R6: pointer persists across reads
    read_open(7'h4C, "R6 read ack");
    expect_rd(8'hA5, "R6 persisted high");
    expect_rd(8'h3C, "R6 persisted low");
    recv_byte(1); recv_byte(0);
    bus_stop();

    // R3: wrong address never acknowledged
    bus_start();
    send_byte({7'h4D, 1'b0}, -1, 0, b0);
    send_byte(8'h00, -1, 0, b1);
    bus_stop();
    chk(!b0, "R3 mismatch address nack", b0, 0);
    chk(!b1, "R3 mismatch data nack", b1, 0);

    // R5: incomplete pair discarded
    bus_start();
    send_byte({7'h4C, 1'b0}, -1, 0, b0);
    send_byte(8'h02, -1, 0, b1);
    send_byte(8'h77, -1, 0, b2);
    bus_stop();
    read_open(7'h4C, "R5 read after partial");
    expect_rd(8'hA5, "R5 partial pair kept high");
    expect_rd(8'h3C, "R5 partial pair kept low");
    recv_byte(1); recv_byte(0);
    bus_stop();

    // R5: several pairs rewrite the same register
    bus_start();
    send_byte({7'h4C, 1'b0}, -1, 0, b0);
    send_byte(8'h05, -1, 0, b1);
    send_byte(8'h11, -1, 0, b2);
    send_byte(8'h22, -1, 0, b2);
    send_byte(8'h33, -1, 0, b2);
    send_byte(8'h44, -1, 0, b2);
    bus_stop();
    read_open(7'h4C, "R5 read after pairs");
    expect_rd(8'h33, "R5 last pair high");
    expect_rd(8'h44, "R5 last pair low");
    recv_byte(1); recv_byte(0);
    bus_stop();

    // R1: repeated START mid-byte aborts the pending pair
    bus_start();
    send_byte({7'h4C, 1'b0}, -1, 0, b0);
    send_byte(8'h05, -1, 0, b1);
    send_byte(8'hEE, -1, 0, b2);
    put_bit(1'b1, 0); put_bit(1'b0, 0); put_bit(1'b1, 0);
    read_open(7'h4C, "R1 restart address ack");
    expect_rd(8'h33, "R1 aborted pair high");
    expect_rd(8'h44, "R1 aborted pair low");
    recv_byte(1); recv_byte(0);
    bus_stop();

    // R7: after NACK the line stays released
    read_open(7'h4C, "R7 read ack");
    expect_rd(8'h33, "R7 byte before nack");
    recv_byte(0);
    b0 = 1;
    for (int i = 0; i < 4; i++) begin get_bit(bl); if (!bl) b0 = 0; end
    chk(b0, "R7 released after nack", b0, 1);
    bus_stop();

    // R4: only low pointer bits select (0x0A -> register 2)
    set_ptr(7'h4C, 8'h0A, "R4 wide pointer ack");
    read_open(7'h4C, "R4 read ack");
    expect_rd(8'hA5, "R4 low pointer bits high");
    expect_rd(8'h3C, "R4 low pointer bits low");
    recv_byte(1); recv_byte(0);
    bus_stop();

    // R9: short glitches on SCL and SDA while SCL high are ignored
    bus_start();
    send_byte({7'h4C, 1'b0}, -1, 0, b0);
    send_byte(8'h07, 3, 1, b1);
    send_byte(8'hC3, 7, 2, b2);
    chk(b0 && b1 && b2, "R9 acks through glitches", {b0, b1, b2}, 3'b111);
    send_byte(8'h5A, 4, 1, b0);
    bus_stop();
    chk(b0, "R9 low byte ack", b0, 1);
    read_open(7'h4C, "R9 read ack");
    expect_rd(8'hC3, "R9 glitched write high");
    expect_rd(8'h5A, "R9 glitched write low");
    recv_byte(1); recv_byte(0);
    bus_stop();

    // R2: strap decoding
    do_reset(2'b10, 2'b10);
    ping(7'h37, 1, "R2 straps F,F -> 37");
    ping(7'h4C, 0, "R2 straps F,F reject 4C");
    strap_a0 = 2'b00; strap_a1 = 2'b00;
    ping(7'h37, 1, "R2 late strap change ignored");
    do_reset(2'b01, 2'b10);
    ping(7'h4A, 1, "R2 straps 1,F -> 4A");
    do_reset(2'b11, 2'b01);
    ping(7'h4B, 1, "R2 strap code 11 floating -> 4B");
    do_reset(2'b10, 2'b00);
    ping(7'h49, 1, "R2 straps F,0 -> 49");
    do_reset(2'b00, 2'b01);
    ping(7'h4D, 1, "R2 straps 0,1 -> 4D");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    chk(viol == 0, "R10 pull changes only with SCL low", viol, 0);
    done = 1;
    summary();
    $finish;
  end

endmodule